// File: doc/BRIEF.md
# Stack Pointer Offset Tracker

This block sits in the micro-operation stream just after instruction decode, and the stream passes through it. Each cycle it takes a group of up to four decoded micro-operations. It removes the stack-pointer adjustments that pushes, pops, calls and returns carry, and it adds each one into a signed running offset instead. Those adjustments never reach the execution units. A memory micro-operation that addresses relative to the stack pointer leaves the block with the current running offset attached, so the address path can add it to the stale architectural value.

A micro-operation that names the stack pointer as an explicit operand needs the architectural value to be exact. When the running offset is non-zero, the tracker places a synchronisation micro-operation in front of it. That micro-operation carries the accumulated offset, and the running offset then returns to zero. The same synchronisation is emitted when one more adjustment would push the offset outside its signed range. Only a fixed number of adjustments can be folded per cycle, and the output has a fixed number of slots. When a group needs more than either allows, the block raises a stall and the upstream stage holds the group. The rest of the group is finished in later cycles, in order. A flush discards the offered group and clears the offset.

Top module: `stack_ofs_tracker`

## Requirements
- R1: While reset is asserted and after it is released, every `out_valid` bit is 0 and `in_stall` is 0. The running offset starts at zero, so the first stack-relative memory micro-operation carries offset 0.
- R2: Kind codes on input are 1 (increment by STEP: pop or return), 2 (decrement by STEP: push or call), 3 (stack-relative memory access), 4 (explicit stack-pointer use), and any other value is an ordinary micro-operation. Codes 1 and 2 produce no output and change the running offset by +STEP or -STEP. All others are emitted in input order, packed from slot 0 upward, with their tag unchanged. Ordinary ones leave with kind code 0.
- R3: At most ADDERS adjustments are folded in one cycle. If a group holds more, `in_stall` is 1 in that cycle, and the remaining adjustments are folded in the next cycle while the group is held.
- R4: A stack-relative memory micro-operation leaves with `out_ofs` equal to the running offset at its position, including adjustments earlier in the same group. Ordinary and explicit-use micro-operations leave with offset 0.
- R5: An explicit-use micro-operation seen with a non-zero running offset is preceded, in the next slot down, by a synchronisation micro-operation (kind code 5) whose offset is the running offset. The running offset then becomes zero. With a zero offset, no synchronisation is emitted.
- R6: If the micro-operations still to be emitted do not fit in the output slots, `in_stall` is 1. The ones that fit are emitted, and the rest follow in the next cycle, in order. Valid output slots always form a contiguous run starting at slot 0.
- R7: If an adjustment would take the running offset outside the signed DW-bit range, a synchronisation micro-operation carrying the old offset is emitted first. The running offset then becomes just that one adjustment (±STEP).
- R8: While `flush` is 1, the offered group is dropped, `in_stall` is 0, and the cycle after shows no valid output. The running offset is zero afterwards.
- R9: Outputs are registered: a group accepted in a cycle appears on the outputs after the next rising clock edge, while `in_stall` reflects the offered group in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop offered group and clear running offset |
| in_valid | input | LANES | Per-lane valid of the offered group |
| in_kind | input | 3*LANES | Per-lane kind code |
| in_tag | input | TW*LANES | Per-lane payload tag |
| in_stall | output | 1 | Group not fully consumed; hold it next cycle |
| out_valid | output | LANES | Per-slot valid, packed from slot 0 |
| out_kind | output | 3*LANES | Per-slot output kind code |
| out_tag | output | TW*LANES | Per-slot tag |
| out_ofs | output | DW*LANES | Per-slot signed offset |

## Verification
The assertions check on every cycle that valid output slots are packed from slot 0 and that every synchronisation micro-operation carries a non-zero offset. They also check that ordinary micro-operations carry no offset, that reset clears the outputs and that a flush empties the next output. Only the directed scenarios can show the arithmetic itself: offsets accumulated across groups, the cap on folds per cycle with its stall-and-resume, and the split of a group that overflows the output slots. The same goes for the saturation boundary at the most negative offset and the zero offset after a flush.

// File: rtl/sot_pkg.sv
package sot_pkg;
  localparam int KW = 3;
  typedef enum logic [KW-1:0] {
    K_OTHER = 3'd0,
    K_INC   = 3'd1,
    K_DEC   = 3'd2,
    K_MEM   = 3'd3,
    K_EXPL  = 3'd4,
    K_SYNC  = 3'd5
  } kind_e;
endpackage

// File: rtl/sot_rst_sync.sv
module sot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end
  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/sot_walk.sv
module sot_walk
  import sot_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDERS = 3,
  parameter int DW     = 8,
  parameter int TW     = 8,
  parameter int STEP   = 4
) (
  input  logic [LANES-1:0]        eff_valid,
  input  logic [LANES*KW-1:0]     kind_in,
  input  logic [LANES*TW-1:0]     tag_in,
  input  logic [DW-1:0]           delta_in,
  output logic [LANES-1:0]        take,
  output logic [LANES-1:0]        o_valid,
  output logic [LANES*KW-1:0]     o_kind,
  output logic [LANES*TW-1:0]     o_tag,
  output logic [LANES*DW-1:0]     o_ofs,
  output logic [DW-1:0]           delta_out
);
  localparam logic signed [DW:0] DMAX   = (DW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [DW:0] DMIN   = -(DW+1)'(1 << (DW-1));
  localparam logic signed [DW:0] STEP_S = (DW+1)'(STEP);

  always_comb begin
    logic signed [DW:0] d;
    logic signed [DW:0] nd;
    logic [KW-1:0]      k;
    logic [TW-1:0]      t;
    logic               ovf;
    logic               stop;
    int                 adds;
    int                 slots;
    int                 need;
    take     = '0;
    o_valid  = '0;
    o_kind   = '0;
    o_tag    = '0;
    o_ofs    = '0;
    d        = {delta_in[DW-1], delta_in};
    nd       = '0;
    ovf      = 1'b0;
    stop     = 1'b0;
    adds     = 0;
    slots    = 0;
    need     = 0;
    for (int i = 0; i < LANES; i++) begin
      k = kind_in[i*KW +: KW];
      t = tag_in[i*TW +: TW];
      if (eff_valid[i] && !stop) begin
        case (k)
          K_INC, K_DEC: begin
            nd  = (k == K_INC) ? d + STEP_S : d - STEP_S;
            ovf = (nd > DMAX) || (nd < DMIN);
            if (adds >= ADDERS || (ovf && slots >= LANES)) begin
              stop = 1'b1;
            end else begin
              if (ovf) begin
                o_valid[slots]           = 1'b1;
                o_kind[slots*KW +: KW]   = K_SYNC;
                o_ofs[slots*DW +: DW]    = d[DW-1:0];
                slots                    = slots + 1;
                nd = (k == K_INC) ? STEP_S : -STEP_S;
              end
              d       = nd;
              adds    = adds + 1;
              take[i] = 1'b1;
            end
          end
          K_EXPL: begin
            need = (d != 0) ? 2 : 1;
            if (slots + need > LANES) begin
              stop = 1'b1;
            end else begin
              if (d != 0) begin
                o_valid[slots]           = 1'b1;
                o_kind[slots*KW +: KW]   = K_SYNC;
                o_ofs[slots*DW +: DW]    = d[DW-1:0];
                slots                    = slots + 1;
                d                        = '0;
              end
              o_valid[slots]         = 1'b1;
              o_kind[slots*KW +: KW] = K_EXPL;
              o_tag[slots*TW +: TW]  = t;
              slots                  = slots + 1;
              take[i]                = 1'b1;
            end
          end
          K_MEM: begin
            if (slots >= LANES) begin
              stop = 1'b1;
            end else begin
              o_valid[slots]         = 1'b1;
              o_kind[slots*KW +: KW] = K_MEM;
              o_tag[slots*TW +: TW]  = t;
              o_ofs[slots*DW +: DW]  = d[DW-1:0];
              slots                  = slots + 1;
              take[i]                = 1'b1;
            end
          end
          default: begin
            if (slots >= LANES) begin
              stop = 1'b1;
            end else begin
              o_valid[slots]         = 1'b1;
              o_kind[slots*KW +: KW] = K_OTHER;
              o_tag[slots*TW +: TW]  = t;
              slots                  = slots + 1;
              take[i]                = 1'b1;
            end
          end
        endcase
      end
    end
    delta_out = d[DW-1:0];
  end
endmodule

// File: rtl/sot_state.sv
module sot_state #(
  parameter int LANES = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DW-1:0]    delta_d,
  input  logic [LANES-1:0] done_d,
  output logic [DW-1:0]    delta_q,
  output logic [LANES-1:0] done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
      done_q  <= '0;
    end else if (en) begin
      delta_q <= delta_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/sot_oreg.sv
module sot_oreg
  import sot_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int TW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    valid_d,
  input  logic [LANES*KW-1:0] kind_d,
  input  logic [LANES*TW-1:0] tag_d,
  input  logic [LANES*DW-1:0] ofs_d,
  output logic [LANES-1:0]    valid_q,
  output logic [LANES*KW-1:0] kind_q,
  output logic [LANES*TW-1:0] tag_q,
  output logic [LANES*DW-1:0] ofs_q
);
  logic load;
  assign load = |valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      tag_q  <= '0;
      ofs_q  <= '0;
    end else if (load) begin
      kind_q <= kind_d;
      tag_q  <= tag_d;
      ofs_q  <= ofs_d;
    end
  end
endmodule

// File: rtl/stack_ofs_tracker.sv
module stack_ofs_tracker
  import sot_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDERS = 3,
  parameter int DW     = 8,
  parameter int TW     = 8,
  parameter int STEP   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES*3-1:0]  in_kind,
  input  logic [LANES*TW-1:0] in_tag,
  output logic                in_stall,
  output logic [LANES-1:0]    out_valid,
  output logic [LANES*3-1:0]  out_kind,
  output logic [LANES*TW-1:0] out_tag,
  output logic [LANES*DW-1:0] out_ofs
);
  logic                rst_n_i;
  logic [DW-1:0]       delta_q, delta_d, walk_delta;
  logic [LANES-1:0]    done_q, done_d, eff_valid, take;
  logic [LANES-1:0]    w_valid, o_valid_d;
  logic [LANES*KW-1:0] w_kind;
  logic [LANES*TW-1:0] w_tag;
  logic [LANES*DW-1:0] w_ofs;
  logic                st_en;

  sot_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  assign eff_valid = in_valid & ~done_q;

  sot_walk #(.LANES(LANES), .ADDERS(ADDERS), .DW(DW), .TW(TW), .STEP(STEP)) u_walk (
    .eff_valid(eff_valid), .kind_in(in_kind), .tag_in(in_tag), .delta_in(delta_q),
    .take(take), .o_valid(w_valid), .o_kind(w_kind), .o_tag(w_tag), .o_ofs(w_ofs),
    .delta_out(walk_delta)
  );

  always_comb begin
    in_stall  = !flush && |(eff_valid & ~take);
    done_d    = '0;
    delta_d   = walk_delta;
    o_valid_d = w_valid;
    if (flush) begin
      delta_d   = '0;
      o_valid_d = '0;
    end else if (in_stall) begin
      done_d = done_q | take;
    end
    st_en = flush || (|eff_valid);
  end

  sot_state #(.LANES(LANES), .DW(DW)) u_state (
    .clk(clk), .rst_n(rst_n_i), .en(st_en), .delta_d(delta_d), .done_d(done_d),
    .delta_q(delta_q), .done_q(done_q)
  );

  sot_oreg #(.LANES(LANES), .DW(DW), .TW(TW)) u_oreg (
    .clk(clk), .rst_n(rst_n_i), .valid_d(o_valid_d), .kind_d(w_kind), .tag_d(w_tag),
    .ofs_d(w_ofs), .valid_q(out_valid), .kind_q(out_kind), .tag_q(out_tag), .ofs_q(out_ofs)
  );
endmodule

// File: rtl/sot_chk.sv
module sot_chk
  import sot_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                in_stall,
  input logic [LANES-1:0]    out_valid,
  input logic [LANES*3-1:0]  out_kind,
  input logic [LANES*DW-1:0] out_ofs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (out_valid == '0 && !in_stall || flush)
        else $error("outputs not clear in reset");
    end
  end

  assert_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((LANES'(out_valid + 1'b1)) & out_valid) == '0);

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> out_valid == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_slot
    assert_sync_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && out_kind[g*3 +: 3] == K_SYNC) |-> out_ofs[g*DW +: DW] != '0);
    assert_plain_zero_ofs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && (out_kind[g*3 +: 3] == K_OTHER || out_kind[g*3 +: 3] == K_EXPL))
      |-> out_ofs[g*DW +: DW] == '0);
  end
endmodule

bind stack_ofs_tracker sot_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_stall(in_stall),
  .out_valid(out_valid), .out_kind(out_kind), .out_ofs(out_ofs)
);

// File: tb/sim_stack_ofs_tracker.sv
`timescale 1ns/1ps
module sim_stack_ofs_tracker;
  localparam int LANES = 4;
  localparam int DW = 8;
  localparam int TW = 8;

  logic clk, rst_n, flush;
  logic [LANES-1:0]    in_valid;
  logic [LANES*3-1:0]  in_kind;
  logic [LANES*TW-1:0] in_tag;
  logic                in_stall;
  logic [LANES-1:0]    out_valid;
  logic [LANES*3-1:0]  out_kind;
  logic [LANES*TW-1:0] out_tag;
  logic [LANES*DW-1:0] out_ofs;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  stack_ofs_tracker u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_kind(in_kind),
    .in_tag(in_tag), .in_stall(in_stall), .out_valid(out_valid), .out_kind(out_kind),
    .out_tag(out_tag), .out_ofs(out_ofs)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    in_valid = '0; in_kind = '0; in_tag = '0;
  endtask

  task automatic lane(int i, int k, int t);
    in_valid[i] = 1'b1;
    in_kind[i*3 +: 3] = 3'(k);
    in_tag[i*TW +: TW] = TW'(t);
  endtask

  task automatic slot(string req, int s, int k, int t, int ofs);
    chk(req, $sformatf("slot%0d valid", s), int'(out_valid[s]), 1);
    chk(req, $sformatf("slot%0d kind", s), int'(out_kind[s*3 +: 3]), k);
    chk(req, $sformatf("slot%0d tag", s), int'(out_tag[s*TW +: TW]), t);
    chk(req, $sformatf("slot%0d ofs", s), int'($signed(out_ofs[s*DW +: DW])), ofs);
  endtask

  // one memory op alone; verifies running offset
  task automatic probe(string req, int t, int exp_ofs);
    clr(); lane(0, 3, t);
    tick(); clr();
    chk(req, "probe valid", int'(out_valid), 1);
    slot(req, 0, 3, t, exp_ofs);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; flush = 1'b0; clr();
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "stall in reset", int'(in_stall), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1", "valid after reset", int'(out_valid), 0);
    probe("R1", 1, 0);
  endtask

  task automatic t_fold();
    clr(); lane(0, 0, 10); lane(1, 2, 0); lane(2, 0, 11); lane(3, 3, 12);
    #1 chk("R2", "stall", int'(in_stall), 0);
    tick(); clr();
    chk("R2", "packed valid", int'(out_valid), 4'b0111);
    slot("R2", 0, 0, 10, 0);
    slot("R2", 1, 0, 11, 0);
    slot("R4", 2, 3, 12, -4);
    clr(); lane(0, 2, 0); lane(1, 2, 0); lane(2, 3, 13);
    tick(); clr();
    chk("R9", "one-cycle output", int'(out_valid), 1);
    slot("R4", 0, 3, 13, -12);
  endtask

  task automatic t_adders();
    clr(); lane(0, 1, 0); lane(1, 1, 0); lane(2, 1, 0); lane(3, 1, 0);
    #1 chk("R3", "stall on fourth update", int'(in_stall), 1);
    tick();
    chk("R3", "no output", int'(out_valid), 0);
    chk("R3", "stall released", int'(in_stall), 0);
    tick(); clr();
    probe("R3", 20, 4);
  endtask

  task automatic t_sync();
    clr(); lane(0, 4, 30);
    tick(); clr();
    chk("R5", "sync+use valid", int'(out_valid), 4'b0011);
    slot("R5", 0, 5, 0, 4);
    slot("R5", 1, 4, 30, 0);
    clr(); lane(0, 4, 31);
    tick(); clr();
    chk("R5", "no sync at zero", int'(out_valid), 1);
    slot("R5", 0, 4, 31, 0);
    probe("R5", 32, 0);
  endtask

  task automatic t_slots();
    clr(); lane(0, 2, 0);
    tick(); clr();
    chk("R2", "update only no output", int'(out_valid), 0);
    lane(0, 0, 40); lane(1, 0, 41); lane(2, 0, 42); lane(3, 4, 43);
    #1 chk("R6", "stall no room", int'(in_stall), 1);
    tick();
    chk("R6", "first part", int'(out_valid), 4'b0111);
    slot("R6", 0, 0, 40, 0);
    slot("R6", 2, 0, 42, 0);
    chk("R6", "stall released", int'(in_stall), 0);
    tick(); clr();
    chk("R6", "second part", int'(out_valid), 4'b0011);
    slot("R6", 0, 5, 0, -4);
    slot("R6", 1, 4, 43, 0);
  endtask

  task automatic t_ovf();
    for (int g = 0; g < 10; g++) begin
      clr(); lane(0, 2, 0); lane(1, 2, 0); lane(2, 2, 0);
      tick();
    end
    chk("R7", "no output before limit", int'(out_valid), 0);
    clr(); lane(0, 2, 0); lane(1, 2, 0); lane(2, 2, 0);
    tick(); clr();
    chk("R7", "sync on overflow", int'(out_valid), 1);
    slot("R7", 0, 5, 0, -128);
    probe("R7", 50, -4);
  endtask

  task automatic t_flush();
    clr(); lane(0, 3, 60); lane(1, 2, 0);
    flush = 1'b1;
    #1 chk("R8", "stall during flush", int'(in_stall), 0);
    tick(); flush = 1'b0; clr();
    chk("R8", "dropped group", int'(out_valid), 0);
    probe("R8", 61, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fold();
    t_adders();
    t_sync();
    t_slots();
    t_ovf();
    t_flush();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule